// File: doc/BRIEF.md
# Packed SIMD Leading-Bit Counter

This execution unit takes one 256-bit vector operand and, in every lane independently, counts how many of the most significant bits are zero, or how many are one. The lane width (8, 16, 32 or 64 bits) and the counting polarity are chosen for each operation from a 5-bit minor-opcode field. One partitioned counter is shared by all widths. Every byte gets an 8-bit leading-zero count. Adjacent counts are then merged in pairs into 16-, 32- and 64-bit counts. Counting ones is done by inverting the operand before the shared counter.

The result is registered. One cycle after a valid request, `valid_o` rises and `result_o` holds the new vector. Each count is an unsigned value in the least significant bits of its own lane, with the rest of the lane cleared. A minor-opcode value outside the supported range raises `illegal_o` for one cycle and leaves the result register untouched.

Top module: `lead_bit_counter`

## Requirements
- R1: The minor opcode selects the operation. Bit 2 set means count leading zeros and bit 2 clear means count leading ones. Bits 1:0 give the lane width: 0 for 8, 1 for 16, 2 for 32 and 3 for 64 bits. Values 0 to 7 are the only legal ones.
- R2: Each lane of `result_o` holds the count for the source lane at the same position, zero-extended to fill the lane. The lane's most significant bit is the first bit counted, and no lane affects another.
- R3: A lane with no terminating bit returns the full lane width (8, 16, 32 or 64). That is an all-zero lane when counting zeros, or an all-one lane when counting ones.
- R4: Counting leading ones of a source gives the same result as counting leading zeros of its bitwise inverse.
- R5: For a valid request with a minor opcode from 8 to 31, `illegal_o` is 1 and `valid_o` is 0 in the next cycle, and `result_o` is unchanged.
- R6: For a valid legal request, `valid_o` is 1 and `result_o` holds the new counts exactly one clock cycle later.
- R7: While reset is asserted, `result_o`, `valid_o` and `illegal_o` are all zero.
- R8: In a cycle after one without a valid request, `valid_o` and `illegal_o` are 0 and `result_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| minor_op_i | input | 5 | Minor opcode: polarity and lane width |
| src_i | input | 256 | Source vector |
| valid_o | output | 1 | Result register updated by a legal request |
| illegal_o | output | 1 | Previous request had an unsupported opcode |
| result_o | output | 256 | Per-lane leading-bit counts |

## Verification
The assertions assume that `valid_i`, `minor_op_i` and `src_i` are stable and known at each rising edge. The hold and latency properties assume that nothing except a legal request may change the result register. The bench drives its inputs only on falling edges and leaves `valid_i` low between requests, so every hold property is exercised. The bench sweeps a single set bit and a single clear bit across all 256 positions for every legal opcode. This reaches each count value in every lane width. Pseudo-random operands and all 24 unsupported opcodes are applied as well.

// File: rtl/lcnt_pkg.sv
package lcnt_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } lane_sz_e;

  typedef struct packed {
    logic     legal;
    logic     ones;
    lane_sz_e sz;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [4:0] op);
    op_dec_t d;
    d.legal = (op[4:3] == 2'b00);
    d.ones  = ~op[2];
    d.sz    = lane_sz_e'(op[1:0]);
    return d;
  endfunction

endpackage

// File: rtl/lcnt_byte_lzc.sv
module lcnt_byte_lzc (
  input  logic [7:0] data_i,
  output logic [3:0] cnt_o
);

  always_comb begin
    cnt_o = 4'd8;
    for (int b = 0; b < 8; b++) begin
      if (data_i[b]) cnt_o = 4'(7 - b);
    end
  end

endmodule

// File: rtl/lcnt_merge.sv
module lcnt_merge #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] lo_i,
  output logic [CW:0]   cnt_o
);

  // MSB of a count is set only when its half was all zero
  assign cnt_o = hi_i[CW-1] ? ({1'b0, hi_i} + {1'b0, lo_i}) : {1'b0, hi_i};

endmodule

// File: rtl/lcnt_partition.sv
module lcnt_partition
  import lcnt_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic [DATA_W-1:0] vec_i,
  input  lane_sz_e          sz_i,
  output logic [DATA_W-1:0] cnt_o
);

  localparam int NB = DATA_W / 8;
  localparam int NH = NB / 2;
  localparam int NW = NB / 4;
  localparam int ND = NB / 8;

  logic [3:0] c8  [NB];
  logic [4:0] c16 [NH];
  logic [5:0] c32 [NW];
  logic [6:0] c64 [ND];

  for (genvar i = 0; i < NB; i++) begin : g_byte
    lcnt_byte_lzc u_lzc (.data_i(vec_i[8*i +: 8]), .cnt_o(c8[i]));
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    lcnt_merge #(.CW(4)) u_m (.hi_i(c8[2*i+1]), .lo_i(c8[2*i]), .cnt_o(c16[i]));
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    lcnt_merge #(.CW(5)) u_m (.hi_i(c16[2*i+1]), .lo_i(c16[2*i]), .cnt_o(c32[i]));
  end

  for (genvar i = 0; i < ND; i++) begin : g_dword
    lcnt_merge #(.CW(6)) u_m (.hi_i(c32[2*i+1]), .lo_i(c32[2*i]), .cnt_o(c64[i]));
  end

  // Count lands in the lowest byte of its lane; upper bytes are cleared
  for (genvar b = 0; b < NB; b++) begin : g_out
    logic [7:0] ob, oh, ow, od;
    assign ob = {4'b0, c8[b]};
    if (b % 2 == 0) begin : g_h
      assign oh = {3'b0, c16[b/2]};
    end else begin : g_hz
      assign oh = '0;
    end
    if (b % 4 == 0) begin : g_w
      assign ow = {2'b0, c32[b/4]};
    end else begin : g_wz
      assign ow = '0;
    end
    if (b % 8 == 0) begin : g_d
      assign od = {1'b0, c64[b/8]};
    end else begin : g_dz
      assign od = '0;
    end
    always_comb begin
      unique case (sz_i)
        SZ_B:    cnt_o[8*b +: 8] = ob;
        SZ_H:    cnt_o[8*b +: 8] = oh;
        SZ_W:    cnt_o[8*b +: 8] = ow;
        default: cnt_o[8*b +: 8] = od;
      endcase
    end
  end

endmodule

// File: rtl/lead_bit_counter.sv
module lead_bit_counter
  import lcnt_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int OP_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   minor_op_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int NB = DATA_W / 8;

  op_dec_t           dec;
  logic [DATA_W-1:0] cnt_src;
  logic [DATA_W-1:0] cnt_vec;
  logic [DATA_W-1:0] result_q;
  logic              valid_q, illegal_q;

  assign dec     = decode_op(minor_op_i[4:0]);
  assign cnt_src = src_i ^ {DATA_W{dec.ones}};

  lcnt_partition #(.DATA_W(DATA_W)) u_part (
    .vec_i (cnt_src),
    .sz_i  (dec.sz),
    .cnt_o (cnt_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q  <= '0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q   <= valid_i & dec.legal;
      illegal_q <= valid_i & ~dec.legal;
      if (valid_i && dec.legal) result_q <= cnt_vec;
    end
  end

  assign result_o  = result_q;
  assign valid_o   = valid_q;
  assign illegal_o = illegal_q;

  p_valid_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && minor_op_i < 5'd8) |=> (valid_o && !illegal_o));

  p_illegal_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && minor_op_i >= 5'd8) |=> (illegal_o && !valid_o && $stable(result_o)));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !illegal_o && $stable(result_o)));

  p_flags_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o));

  p_zero_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && minor_op_i == 5'd4 && src_i == '0) |=> (result_o == {NB{8'd8}}));

  p_ones_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && minor_op_i == 5'd0 && src_i == '1) |=> (result_o == {NB{8'd8}}));

endmodule

// File: tb/lead_bit_counter_bench.sv
`timescale 1ns/1ps
module lead_bit_counter_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [4:0]   op_i = '0;
  logic [255:0] src_i = '0;
  logic         valid_o, illegal_o;
  logic [255:0] result_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  lead_bit_counter u_lead_bit_counter (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .minor_op_i(op_i),
    .src_i(src_i), .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  function automatic logic [255:0] model(input logic [4:0] op, input logic [255:0] s);
    logic [255:0] r = '0;
    int w = 8 << op[1:0];
    for (int l = 0; l < 256 / w; l++) begin
      int  cnt = 0;
      bit  seen = 0;
      for (int b = w - 1; b >= 0; b--) begin
        bit v = s[l*w + b] ^ ~op[2];
        if (!seen && !v) cnt++;
        else seen = 1;
      end
      r[l*w +: 8] = 8'(cnt);
    end
    return r;
  endfunction

  function automatic logic [63:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr;
  endfunction

  function automatic logic [255:0] rand_vec();
    return {next_rand(), next_rand(), next_rand(), next_rand()};
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [255:0] s);
    @(negedge clk);
    valid_i = 1'b1;
    op_i    = op;
    src_i   = s;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run(input logic [4:0] op, input logic [255:0] s, input string req);
    logic [255:0] e = model(op, s);
    issue(op, s);
    check(valid_o && !illegal_o && result_o == e, req, result_o, e);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] held, s, a;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(result_o == '0 && !valid_o && !illegal_o, "R7 reset", result_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(result_o == '0 && !valid_o, "R7 after release", result_o, '0);

    // R3: full-width counts for every size and polarity
    for (int op = 0; op < 8; op++) begin
      run(5'(op), '0, "R3 all zero");
      run(5'(op), '1, "R3 all one");
    end

    // R2 / R1: walking one and walking zero across every position
    for (int k = 0; k < 256; k++) begin
      for (int op = 0; op < 8; op++) begin
        run(5'(op), 256'b1 << k, "R2 walking one");
        run(5'(op), ~(256'b1 << k), "R2 walking zero");
      end
    end

    // R1: pseudo-random operands with varied leading runs
    for (int n = 0; n < 300; n++) begin
      s = rand_vec() & rand_vec() & rand_vec();
      if (n % 2 == 1) s = ~s;
      for (int op = 0; op < 8; op++) run(5'(op), s, "R1 random");
    end

    // R4: ones on source equals zeros on inverse, compared at the ports
    for (int n = 0; n < 40; n++) begin
      s = rand_vec() | rand_vec();
      for (int sz = 0; sz < 4; sz++) begin
        issue(5'(sz), s);
        a = result_o;
        issue(5'(sz + 4), ~s);
        check(result_o == a, "R4 polarity", result_o, a);
      end
    end

    // R6: one-cycle latency
    @(negedge clk);
    valid_i = 1'b1; op_i = 5'd5; src_i = {16{16'h00F0}};
    @(posedge clk); #1;
    check(valid_o && result_o == model(5'd5, {16{16'h00F0}}), "R6 latency", result_o,
          model(5'd5, {16{16'h00F0}}));
    @(negedge clk); valid_i = 1'b0;

    // R5: unsupported opcodes leave result untouched
    for (int op = 8; op < 32; op++) begin
      run(5'd7, rand_vec(), "R1 before illegal");
      held = result_o;
      issue(5'(op), rand_vec());
      check(illegal_o && !valid_o && result_o == held, "R5 illegal", result_o, held);
    end

    // R8: idle cycles hold the result
    held = result_o;
    repeat (4) begin
      @(negedge clk);
      check(!valid_o && !illegal_o && result_o == held, "R8 idle", result_o, held);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule